// File: doc/BRIEF.md
# Flexible Second-Operand Shifter

This combinational unit forms the second operand of a 32-bit arithmetic or logic operation and the carry that the shifter passes on to the flags. The operand can take one of three forms. The first is a byte constant that is rotated right by an even amount. The second is a register value shifted by a 5-bit constant. The third is a register value shifted by the low byte of a second register. A decoder upstream chooses the form, the shift kind and the fields. The register file supplies the register values. The datapath then takes the operand and the carry in the same cycle.

The design is split into three parts. A request selector turns each operand form into one uniform shift request: a base value, a shift kind, an amount and a rotate-through-carry flag. A shift core carries out that request. The top module wires the two together. All special amount cases are folded into the request, so the core follows a single rule set: amount zero passes the value through, and amounts at or beyond the word width saturate.

Top module: `opshift_unit`

## Requirements
- R1: With form_sel = 0 (immediate form), the result is imm_byte zero-extended to 32 bits and rotated right by twice imm_rot. shift_kind, src_val, const_amt and amt_reg have no effect in this form.
- R2: In immediate form, carry_out equals result bit 31 when imm_rot is nonzero, and equals carry_in when imm_rot is zero.
- R3: With form_sel = 1 (constant form) and const_amt = n, 1..31, the shift kinds behave as follows. shift_kind 0 shifts left logically with carry_out = src_val[32-n]. shift_kind 1 shifts right logically and shift_kind 2 shifts right arithmetically, both with carry_out = src_val[n-1]. shift_kind 3 rotates right with carry_out = result bit 31.
- R4: In constant form with const_amt = 0, each kind is treated as follows. A left shift passes src_val through with carry_out = carry_in. A logical right shift gives 0 with carry_out = src_val[31]. An arithmetic right shift gives 32 copies of src_val[31] with carry_out = src_val[31].
- R5: In constant form, a rotate with const_amt = 0 gives {carry_in, src_val[31:1]} with carry_out = src_val[0].
- R6: With form_sel[1] = 1 (register form), only amt_reg[7:0] sets the amount. Bits 31:8 of amt_reg have no effect on the result or the carry. For amounts 1..31 the rules of R3 apply.
- R7: In register form with amt_reg[7:0] = 0, every shift kind passes src_val through with carry_out = carry_in.
- R8: In register form, logical shifts of exactly 32 give 0. The carry is src_val[0] for a left shift and src_val[31] for a right shift. Logical shifts of more than 32 give 0 with carry_out = 0.
- R9: In register form, an arithmetic right shift by 32 or more gives 32 copies of src_val[31] with carry_out = src_val[31]. A rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged with carry_out = src_val[31].
- R10: form_sel values 2 and 3 both select register form. The shift_kind encoding is 0 = left logical, 1 = right logical, 2 = right arithmetic, 3 = rotate right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_sel | input | 2 | Operand form: 0 immediate, 1 constant shift, 2/3 register shift |
| shift_kind | input | 2 | Shift kind for the two shift forms |
| imm_byte | input | 8 | Byte constant for immediate form |
| imm_rot | input | 4 | Half of the rotate amount for immediate form |
| src_val | input | 32 | Register value to be shifted |
| const_amt | input | 5 | Constant shift amount |
| amt_reg | input | 32 | Register holding the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Value shifting and carry generation are evaluated in the same cycle, and they share the amount decode. The case most likely to break is the 32 boundary. There the result saturates while the carry must still take the last bit shifted out, or must drop to zero just beyond it. The bench sweeps every register amount byte, every shift kind and both carry-in levels over several bit patterns, and every immediate byte and rotate combination as well. It judges each result and carry against a reference that shifts one bit at a time.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    localparam int OPS_AMT_W = 8;

    typedef enum logic [1:0] {
        FORM_IMM     = 2'd0,
        FORM_CONST   = 2'd1,
        FORM_REG     = 2'd2,
        FORM_REG_ALT = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        shift_e               kind;
        logic [OPS_AMT_W-1:0] amt;
        logic                 rrx;
    } shift_req_t;

endpackage

// File: rtl/opshift_select.sv
module opshift_select
    import opshift_pkg::*;
#(
    parameter int W      = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int CAMT_W = 5
) (
    input  logic [1:0]        form_sel,
    input  logic [1:0]        shift_kind,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [W-1:0]      src_val,
    input  logic [CAMT_W-1:0] const_amt,
    input  logic [W-1:0]      amt_reg,
    output logic [W-1:0]      base_val,
    output shift_req_t        req
);

    localparam logic [OPS_AMT_W-1:0] FULL_AMT = OPS_AMT_W'(W);

    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_reg[W-1:OPS_AMT_W];

    always_comb begin
        base_val = src_val;
        req.kind = shift_e'(shift_kind);
        req.amt  = '0;
        req.rrx  = 1'b0;
        unique case (form_e'(form_sel))
            FORM_IMM: begin
                base_val = W'(imm_byte);
                req.kind = SH_ROR;
                req.amt  = OPS_AMT_W'({imm_rot, 1'b0});
            end
            FORM_CONST: begin
                if (const_amt == '0) begin
                    unique case (shift_e'(shift_kind))
                        SH_LSL: req.amt = '0;
                        SH_LSR: req.amt = FULL_AMT;
                        SH_ASR: req.amt = FULL_AMT;
                        SH_ROR: req.rrx = 1'b1;
                    endcase
                end else begin
                    req.amt = OPS_AMT_W'(const_amt);
                end
            end
            FORM_REG, FORM_REG_ALT: begin
                req.amt = amt_reg[OPS_AMT_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] base_val,
    input  shift_req_t   req,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int AW = $clog2(W);
    localparam logic [OPS_AMT_W-1:0] FULL_AMT = OPS_AMT_W'(W);

    logic [W:0]             left_wide;
    logic [W:0]             right_wide;
    logic signed [W:0]      arith_wide;
    logic [OPS_AMT_W-1:0]   arith_amt;
    logic [AW-1:0]          rot_m;
    logic [2*W-1:0]         rot_dbl;

    always_comb begin
        left_wide  = {1'b0, base_val} << req.amt;
        right_wide = {base_val, 1'b0} >> req.amt;
        arith_amt  = (req.amt > FULL_AMT) ? FULL_AMT : req.amt;
        arith_wide = $signed({base_val, 1'b0}) >>> arith_amt;
        rot_m      = req.amt[AW-1:0];
        rot_dbl    = {base_val, base_val} >> rot_m;
    end

    always_comb begin
        res  = base_val;
        cout = cin;
        if (req.rrx) begin
            res  = {cin, base_val[W-1:1]};
            cout = base_val[0];
        end else if (req.amt != '0) begin
            unique case (req.kind)
                SH_LSL: begin
                    res  = left_wide[W-1:0];
                    cout = left_wide[W];
                end
                SH_LSR: begin
                    res  = right_wide[W:1];
                    cout = right_wide[0];
                end
                SH_ASR: begin
                    res  = arith_wide[W:1];
                    cout = arith_wide[0];
                end
                SH_ROR: begin
                    res  = rot_dbl[W-1:0];
                    cout = rot_dbl[W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int W      = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int CAMT_W = 5
) (
    input  logic [1:0]        form_sel,
    input  logic [1:0]        shift_kind,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [W-1:0]      src_val,
    input  logic [CAMT_W-1:0] const_amt,
    input  logic [W-1:0]      amt_reg,
    input  logic              carry_in,
    output logic [W-1:0]      op_out,
    output logic              carry_out
);

    localparam logic [OPS_AMT_W-1:0] FULL_AMT = OPS_AMT_W'(W);

    logic [W-1:0] base_val;
    shift_req_t   req;

    opshift_select #(
        .W(W), .IMM_W(IMM_W), .ROT_W(ROT_W), .CAMT_W(CAMT_W)
    ) sel_i (
        .form_sel  (form_sel),
        .shift_kind(shift_kind),
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .src_val   (src_val),
        .const_amt (const_amt),
        .amt_reg   (amt_reg),
        .base_val  (base_val),
        .req       (req)
    );

    opshift_core #(.W(W)) core_i (
        .base_val(base_val),
        .req     (req),
        .cin     (carry_in),
        .res     (op_out),
        .cout    (carry_out)
    );

    // Port-level checks spanning selector and core.
    always_comb begin
        if (form_sel == FORM_IMM && imm_rot == '0) begin
            a_r2_imm_norot: assert (op_out == W'(imm_byte) && carry_out == carry_in)
                else $error("R2: immediate with zero rotate altered value or carry");
        end
        if (form_sel == FORM_IMM && imm_rot != '0) begin
            a_r2_imm_carry: assert (carry_out == op_out[W-1])
                else $error("R2: immediate carry is not result msb");
        end
        if (form_sel == FORM_CONST && shift_kind == SH_ROR && const_amt == '0) begin
            a_r5_rrx_carry: assert (carry_out == src_val[0] && op_out[W-1] == carry_in)
                else $error("R5: rotate through carry wrong");
        end
        if (form_sel[1] && amt_reg[OPS_AMT_W-1:0] == '0) begin
            a_r7_zero_pass: assert (op_out == src_val && carry_out == carry_in)
                else $error("R7: zero register amount not a pass-through");
        end
        if (form_sel[1] && amt_reg[OPS_AMT_W-1:0] > FULL_AMT &&
            (shift_kind == SH_LSL || shift_kind == SH_LSR)) begin
            a_r8_logic_sat: assert (op_out == '0 && !carry_out)
                else $error("R8: logical shift beyond width not zero");
        end
        if (form_sel[1] && amt_reg[OPS_AMT_W-1:0] >= FULL_AMT && shift_kind == SH_ASR) begin
            a_r9_asr_sat: assert (op_out == {W{src_val[W-1]}} && carry_out == src_val[W-1])
                else $error("R9: arithmetic shift beyond width not sign fill");
        end
    end

endmodule

// File: tb/opshift_unit_tb_top.sv
module opshift_unit_tb_top;

    logic        clk = 1'b0;
    logic [1:0]  form_sel;
    logic [1:0]  shift_kind;
    logic [7:0]  imm_byte;
    logic [3:0]  imm_rot;
    logic [31:0] src_val;
    logic [4:0]  const_amt;
    logic [31:0] amt_reg;
    logic        carry_in;
    logic [31:0] op_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    opshift_unit dut_i (
        .form_sel  (form_sel),
        .shift_kind(shift_kind),
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .src_val   (src_val),
        .const_amt (const_amt),
        .amt_reg   (amt_reg),
        .carry_in  (carry_in),
        .op_out    (op_out),
        .carry_out (carry_out)
    );

    // Reference: one bit per step, carry = last bit leaving the word.
    function automatic logic [32:0] step_model(logic [31:0] v, logic [1:0] k, int n, logic c);
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    task automatic apply_check(string tag, logic [31:0] exp_v, logic exp_c);
        @(negedge clk);
        n_checks++;
        if (op_out !== exp_v || carry_out !== exp_c) begin
            n_fails++;
            $display("FAIL %s: form=%0d kind=%0d got op=%h c=%b expected op=%h c=%b",
                     tag, form_sel, shift_kind, op_out, carry_out, exp_v, exp_c);
        end
    endtask

    task automatic drive(logic [1:0] f, logic [1:0] k, logic [7:0] b, logic [3:0] r,
                         logic [31:0] v, logic [4:0] ca, logic [31:0] ar, logic ci);
        @(posedge clk);
        form_sel = f; shift_kind = k; imm_byte = b; imm_rot = r;
        src_val = v; const_amt = ca; amt_reg = ar; carry_in = ci;
    endtask

    logic [31:0] pats [6];

    initial begin
        logic [32:0] e;
        logic [31:0] hi;
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h0000_0001; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;

        // Starting state: immediate zero, no rotate, carry clear (R1)
        drive(2'd0, 2'd0, 8'h00, 4'h0, 32'h0, 5'd0, 32'h0, 1'b0);
        apply_check("R1 start", 32'h0, 1'b0);

        // Immediate form: every byte and rotate, both carries, junk on other inputs
        for (int b = 0; b < 256; b++) begin
            for (int r = 0; r < 16; r++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    drive(2'd0, 2'(b), 8'(b), 4'(r), 32'hDEAD_BEEF, 5'(b), 32'h0000_0011, 1'(ci));
                    e = step_model({24'h0, 8'(b)}, 2'd3, 2 * r, 1'(ci));
                    apply_check(r == 0 ? "R2" : "R1", e[31:0], e[32]);
                end
            end
        end

        // Constant form
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 32; a++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        drive(2'd1, 2'(k), 8'h5A, 4'h7, pats[p], 5'(a), 32'h0000_0003, 1'(ci));
                        if (a != 0) begin
                            e = step_model(pats[p], 2'(k), a, 1'(ci));
                            apply_check("R3", e[31:0], e[32]);
                        end else if (k == 3) begin
                            apply_check("R5", {1'(ci), pats[p][31:1]}, pats[p][0]);
                        end else begin
                            e = step_model(pats[p], 2'(k), (k == 0) ? 0 : 32, 1'(ci));
                            apply_check("R4", e[31:0], e[32]);
                        end
                    end
                end
            end
        end

        // Register form: every amount byte, random upper amount bits
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        hi = $urandom();
                        drive(2'd2, 2'(k), 8'hC3, 4'h9, pats[p], 5'd7,
                              {hi[23:0], 8'(a)}, 1'(ci));
                        e = step_model(pats[p], 2'(k), a, 1'(ci));
                        if (a == 0)
                            apply_check("R7", e[31:0], e[32]);
                        else if (a >= 32 && k < 2)
                            apply_check("R8", e[31:0], e[32]);
                        else if (a >= 32 || k == 3)
                            apply_check("R9", e[31:0], e[32]);
                        else
                            apply_check("R6", e[31:0], e[32]);
                    end
                end
            end
        end

        // Alternate register encoding (R10)
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 40; a++) begin
                drive(2'd3, 2'(k), 8'h00, 4'h0, 32'hC001_0A0B, 5'd1,
                      32'hFF00_0000 | 32'(a), 1'b1);
                e = step_model(32'hC001_0A0B, 2'(k), a, 1'b1);
                apply_check("R10", e[31:0], e[32]);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule